// File: doc/BRIEF.md
# Overlapped Translation and Cache Read Lookup

This block serves read requests from a processor that issues 32-bit virtual addresses. In the cycle a request is accepted, two lookups start side by side: a small fully associative translation buffer searches for the virtual page, and a direct-mapped cache of 1024 one-word lines reads the line chosen by the page-offset bits. Only the page-offset bits pick the line, so the index is ready before translation finishes. The cycle after acceptance, the tag stored in the line is compared with the physical page that the translation buffer produced. A match returns the word. No matching translation returns a translation-miss response, and the requester then performs a full translation elsewhere. A translation hit with a cache miss sends the physical word address to memory, writes the returned word into the line and answers with that word.

The request side is a valid/ready handshake. `req_ready` is high only when the block is idle, and a request moves when `req_valid` and `req_ready` are both high at a clock edge. A request held with `req_ready` low waits and is neither dropped nor queued. Each accepted request produces exactly one response, shown for one cycle on `rsp_valid`. The response cannot be back-pressured. The memory request is valid/ready as well: `mem_req_valid` stays high, with a stable address, until `mem_req_ready` takes it. The memory answer is a one-cycle `mem_rsp_valid` strobe.

The translation buffer is loaded through a plain refill port. Each refill overwrites the slot named by a round-robin pointer.

Top module: `xlat_cache_rd`

## Requirements
- R1: After reset every translation entry and every cache line is invalid. `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0. The first lookup after reset answers with `rsp_tlb_miss`=1.
- R2: When exactly one translation entry matches va[31:12] and the line at va[11:2] is valid with a stored tag equal to that entry's physical page, `rsp_valid` rises in the cycle after acceptance with `rsp_hit`=1 and `rsp_data` equal to the stored word. Every response has exactly one of `rsp_hit`, `rsp_tlb_miss` and `rsp_cache_miss` set.
- R3: When no translation entry matches, the response comes in the cycle after acceptance with `rsp_tlb_miss`=1 and `rsp_hit`=0, and no memory request is issued.
- R4: A translation hit with a cache miss raises `mem_req_valid` with `mem_req_addr` = {physical page, va[11:2], 2'b00}. The address stays stable until `mem_req_ready` is seen.
- R5: The word returned with `mem_rsp_valid` is written into line va[11:2], tagged with the physical page. The response follows one cycle later with `rsp_cache_miss`=1 and `rsp_data` equal to that word. A repeat of the same access then hits.
- R6: From acceptance until its response, `req_ready` stays 0 whatever `req_valid` does, including while a memory answer is outstanding, and no second memory request is issued.
- R7: The hit test compares the line tag with the translated physical page. A different virtual page mapped to the same physical page hits the same line. A virtual page mapped to a different physical page with the same va[11:2] misses and replaces the line.
- R8: The translation buffer has 8 entries. Refills write slots 0,1,...,7,0,... in turn, so the ninth refill replaces the first entry. A refilled entry starts with its referenced bit clear.
- R9: If more than one entry matches, the response has `rsp_tlb_miss`=1, `rsp_multi_err`=1 and `rsp_hit`=0. On an ordinary miss `rsp_multi_err` is 0.
- R10: On responses to translation hits, `rsp_attr`[4] is the entry's dirty bit, `rsp_attr`[3] is its referenced bit as it stood before this lookup, and `rsp_attr`[2:0] are its access-rights bits. Each single-match lookup sets the referenced bit. On translation misses `rsp_attr` is 0.
- R11: Byte-select bits va[1:0] do not affect the lookup. Any of the four byte addresses of a word returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Word read (valid on hit or cache-miss response) |
| rsp_hit | output | 1 | Response was served from the cache |
| rsp_tlb_miss | output | 1 | No usable translation |
| rsp_cache_miss | output | 1 | Served from memory after a line fill |
| rsp_multi_err | output | 1 | More than one translation entry matched |
| rsp_attr | output | 5 | {dirty, referenced-before, rights[2:0]} of the matching entry |
| tlb_wr_en | input | 1 | Refill strobe |
| tlb_wr_vpn | input | 20 | Virtual page of the new entry |
| tlb_wr_ppn | input | 20 | Physical page of the new entry |
| tlb_wr_dirty | input | 1 | Dirty bit of the new entry |
| tlb_wr_rights | input | 3 | Access-rights bits of the new entry |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Physical word address |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The bench builds the block with its default parameters: 8 translation entries, a 12-bit page offset and 1024 lines. With only 8 slots, nine refills are enough to show the round-robin pointer wrapping and overwriting old entries. Loading the same page twice creates the multi-match case. The 10-bit index lets offset 0xFFC reach the last line. Two virtual pages mapped to one physical page show that the tag holds the physical page. A held-off memory model stretches a fill, so the request side can be watched staying closed while the fill is outstanding.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VA_W     = 32;
  parameter int OFF_W    = 12;
  parameter int BSEL_W   = 2;
  parameter int RIGHTS_W = 3;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PPN_W   = 20;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int IDX_W   = OFF_W - BSEL_W;
  localparam int WORD_W  = 8 << BSEL_W;
  localparam int ATTR_W  = RIGHTS_W + 2;

  typedef struct packed {
    logic                vld;
    logic [VPN_W-1:0]    vpn;
    logic [PPN_W-1:0]    ppn;
    logic                dirty;
    logic                refd;
    logic [RIGHTS_W-1:0] rights;
  } xlat_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_FDONE
  } lk_state_e;
endpackage

// File: rtl/xlat_tlb_cam.sv
module xlat_tlb_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic                wr_dirty,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic                lk_en,
  input  logic [VPN_W-1:0]    lk_vpn,
  output logic                hit_q,
  output logic                multi_q,
  output logic [PPN_W-1:0]    ppn_q,
  output logic [ATTR_W-1:0]   attr_q
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xlat_ent_t          ent [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q;
  xlat_ent_t          sel;
  int                 n_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent[g].vld && (ent[g].vpn == lk_vpn);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) sel = sel | ent[i];
    end
    n_match = $countones(match);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
      ptr_q   <= '0;
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      ppn_q   <= '0;
      attr_q  <= '0;
    end else begin
      if (lk_en) begin
        hit_q   <= (n_match == 1);
        multi_q <= (n_match > 1);
        ppn_q   <= sel.ppn;
        attr_q  <= {sel.dirty, sel.refd, sel.rights};
        if (n_match == 1) begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) ent[i].refd <= 1'b1;
          end
        end
      end
      if (wr_en) begin
        ent[ptr_q] <= '{vld: 1'b1, vpn: wr_vpn, ppn: wr_ppn,
                        dirty: wr_dirty, refd: 1'b0, rights: wr_rights};
        ptr_q      <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // R9: a lookup result is never both a clean hit and a multi-match
  p_hit_not_multi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> !multi_q);
endmodule

// File: rtl/xlat_line_store.sv
module xlat_line_store
  import xlat_pkg::*;
#(
  parameter int LIDX_W = IDX_W,
  parameter int TAG_W  = PPN_W,
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [LIDX_W-1:0] rd_idx,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_vld_q,
  output logic [TAG_W-1:0]  rd_tag_q,
  output logic [DATA_W-1:0] rd_data_q
);
  localparam int LINES = 1 << LIDX_W;

  logic [LINES-1:0]  vld_bits;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_bits <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (wr_en) vld_bits[wr_idx] <= 1'b1;
      if (rd_en) rd_vld_q <= vld_bits[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
    if (rd_en) begin
      rd_tag_q  <= tag_mem[rd_idx];
      rd_data_q <= data_mem[rd_idx];
    end
  end

  // R5: a filled line is valid from the next cycle on
  p_fill_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_bits[$past(wr_idx)]);
endmodule

// File: rtl/xlat_lookup_ctrl.sv
module xlat_lookup_ctrl
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              accept,
  input  logic              tlb_hit,
  input  logic              tlb_multi,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [ATTR_W-1:0] tlb_attr,
  input  logic              line_vld,
  input  logic [PPN_W-1:0]  line_tag,
  input  logic [WORD_W-1:0] line_data,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_tlb_miss,
  output logic              rsp_cache_miss,
  output logic              rsp_multi_err,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [PPN_W-1:0]  fill_tag,
  output logic [WORD_W-1:0] fill_data
);
  lk_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic              tag_eq;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign tag_eq        = line_vld && (line_tag == tlb_ppn);
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {tlb_ppn, idx_q, {BSEL_W{1'b0}}};
  assign fill_en       = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign fill_idx      = idx_q;
  assign fill_tag      = tlb_ppn;
  assign fill_data     = mem_rsp_data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_LOOK;
      ST_LOOK:  state_d = (tlb_hit && !tag_eq) ? ST_MREQ : ST_IDLE;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_FDONE;
      ST_FDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_valid      = 1'b0;
    rsp_data       = '0;
    rsp_hit        = 1'b0;
    rsp_tlb_miss   = 1'b0;
    rsp_cache_miss = 1'b0;
    rsp_multi_err  = 1'b0;
    if (state_q == ST_LOOK) begin
      if (!tlb_hit) begin
        rsp_valid     = 1'b1;
        rsp_tlb_miss  = 1'b1;
        rsp_multi_err = tlb_multi;
      end else if (tag_eq) begin
        rsp_valid = 1'b1;
        rsp_hit   = 1'b1;
        rsp_data  = line_data;
      end
    end else if (state_q == ST_FDONE) begin
      rsp_valid      = 1'b1;
      rsp_cache_miss = 1'b1;
      rsp_data       = word_q;
    end
    rsp_attr = (rsp_valid && tlb_hit) ? tlb_attr : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept)  idx_q  <= req_idx;
      if (fill_en) word_q <= mem_rsp_data;
    end
  end

  // R6: once a request is taken the block is closed for the next cycle
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R2: each response carries exactly one outcome
  p_rsp_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_tlb_miss, rsp_cache_miss}) == 1));
  // R4: a waiting memory request keeps its address
  p_memreq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R9: multi-match is reported as a translation miss
  p_multi_means_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi_err) |-> (rsp_tlb_miss && !rsp_hit));
  // R3: a translation miss never leads to a memory request
  p_no_mem_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tlb_miss) |=> !mem_req_valid);
endmodule

// File: rtl/xlat_cache_rd.sv
module xlat_cache_rd
  import xlat_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_data,
  output logic                rsp_hit,
  output logic                rsp_tlb_miss,
  output logic                rsp_cache_miss,
  output logic                rsp_multi_err,
  output logic [ATTR_W-1:0]   rsp_attr,
  input  logic                tlb_wr_en,
  input  logic [VPN_W-1:0]    tlb_wr_vpn,
  input  logic [PPN_W-1:0]    tlb_wr_ppn,
  input  logic                tlb_wr_dirty,
  input  logic [RIGHTS_W-1:0] tlb_wr_rights,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [WORD_W-1:0]   mem_rsp_data
);
  logic              accept;
  logic              tlb_hit, tlb_multi;
  logic [PPN_W-1:0]  tlb_ppn;
  logic [ATTR_W-1:0] tlb_attr;
  logic              line_vld;
  logic [PPN_W-1:0]  line_tag;
  logic [WORD_W-1:0] line_data;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [PPN_W-1:0]  fill_tag;
  logic [WORD_W-1:0] fill_data;
  logic              unused_bsel;

  assign unused_bsel = ^req_vaddr[BSEL_W-1:0];

  xlat_tlb_cam #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tlb_wr_en),
    .wr_vpn   (tlb_wr_vpn),
    .wr_ppn   (tlb_wr_ppn),
    .wr_dirty (tlb_wr_dirty),
    .wr_rights(tlb_wr_rights),
    .lk_en    (accept),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .hit_q    (tlb_hit),
    .multi_q  (tlb_multi),
    .ppn_q    (tlb_ppn),
    .attr_q   (tlb_attr)
  );

  xlat_line_store #(.LIDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(WORD_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (accept),
    .rd_idx   (req_vaddr[OFF_W-1:BSEL_W]),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag),
    .wr_data  (fill_data),
    .rd_vld_q (line_vld),
    .rd_tag_q (line_tag),
    .rd_data_q(line_data)
  );

  xlat_lookup_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_idx       (req_vaddr[OFF_W-1:BSEL_W]),
    .accept        (accept),
    .tlb_hit       (tlb_hit),
    .tlb_multi     (tlb_multi),
    .tlb_ppn       (tlb_ppn),
    .tlb_attr      (tlb_attr),
    .line_vld      (line_vld),
    .line_tag      (line_tag),
    .line_data     (line_data),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .rsp_hit       (rsp_hit),
    .rsp_tlb_miss  (rsp_tlb_miss),
    .rsp_cache_miss(rsp_cache_miss),
    .rsp_multi_err (rsp_multi_err),
    .rsp_attr      (rsp_attr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_en       (fill_en),
    .fill_idx      (fill_idx),
    .fill_tag      (fill_tag),
    .fill_data     (fill_data)
  );
endmodule

// File: tb/xlat_cache_rd_tb_top.sv
module xlat_cache_rd_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_hit, rsp_tlb_miss, rsp_cache_miss, rsp_multi_err;
  logic [4:0]  rsp_attr;
  logic        tlb_wr_en = 1'b0;
  logic [19:0] tlb_wr_vpn = '0;
  logic [19:0] tlb_wr_ppn = '0;
  logic        tlb_wr_dirty = 1'b0;
  logic [2:0]  tlb_wr_rights = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int          n_chk = 0;
  int          n_bad = 0;
  int          mem_cnt = 0;
  logic [31:0] mem_last = '0;
  bit          mem_hold = 1'b0;

  logic        g_valid, g_hit, g_tmiss, g_cmiss, g_multi;
  logic [31:0] g_data;
  logic [4:0]  g_attr;
  int          g_lat;

  always #10 clk = ~clk;

  xlat_cache_rd dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_cache_miss(rsp_cache_miss),
    .rsp_multi_err(rsp_multi_err), .rsp_attr(rsp_attr),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
    .tlb_wr_dirty(tlb_wr_dirty), .tlb_wr_rights(tlb_wr_rights),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [19:0] map_ppn(input logic [19:0] vpn);
    case (vpn)
      20'h00010, 20'h00011: map_ppn = 20'h00A00;
      20'h12345:            map_ppn = 20'h54321;
      default:              map_ppn = vpn ^ 20'hF0F0F;
    endcase
  endfunction

  function automatic logic [31:0] pa_of(input logic [31:0] va);
    pa_of = {map_ppn(va[31:12]), va[11:2], 2'b00};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] pa);
    mem_word = pa ^ 32'hC3C3_5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: takes a request one cycle after it shows, answers later
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        while (mem_hold) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_cnt  <= mem_cnt + 1;
      mem_last <= mem_req_addr;
    end
  end

  task automatic refill(input logic [19:0] vpn, input logic dirty,
                        input logic [2:0] rights);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_ppn = map_ppn(vpn);
    tlb_wr_dirty = dirty; tlb_wr_rights = rights;
    @(negedge clk);
    tlb_wr_en = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 1;
    while (!rsp_valid && g_lat < 300) begin
      @(negedge clk);
      g_lat++;
    end
    g_valid = rsp_valid; g_hit = rsp_hit; g_tmiss = rsp_tlb_miss;
    g_cmiss = rsp_cache_miss; g_multi = rsp_multi_err;
    g_data = rsp_data; g_attr = rsp_attr;
  endtask

  // vector table: {kind, vaddr}; kind 0 = hit, 1 = translation miss, 2 = fill
  localparam logic [33:0] VEC [9] = '{
    {2'd2, 32'h0001_0040},  // first touch fills (R4, R5)
    {2'd0, 32'h0001_0040},  // repeat hits (R2, R5)
    {2'd0, 32'h0001_0043},  // other byte of same word (R11)
    {2'd0, 32'h0001_1040},  // other page, same physical page (R7)
    {2'd2, 32'h1234_5040},  // same index, other physical page (R7)
    {2'd2, 32'h0001_0040},  // evicted line refills (R7)
    {2'd1, 32'h7777_7000},  // no translation (R3)
    {2'd2, 32'h1234_5FFC},  // top line (R4)
    {2'd0, 32'h1234_5FFC}   // top line hits (R2)
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    do_req(32'h0001_0040);
    chk(g_valid && g_tmiss && !g_hit, "R1 first lookup misses translation",
        {29'd0, g_valid, g_tmiss, g_hit}, 32'd6);

    refill(20'h00010, 1'b1, 3'b101);
    refill(20'h00011, 1'b0, 3'b001);
    refill(20'h12345, 1'b0, 3'b111);

    for (int i = 0; i < 9; i++) begin
      logic [1:0]  kind;
      logic [31:0] va;
      int          mc0;
      kind = VEC[i][33:32];
      va   = VEC[i][31:0];
      mc0  = mem_cnt;
      do_req(va);
      chk(g_valid, "R2 response present", 32'(g_valid), 32'd1);
      case (kind)
        2'd0: begin
          chk(g_hit && !g_tmiss && !g_cmiss, "R2 hit flags",
              {29'd0, g_hit, g_tmiss, g_cmiss}, 32'd4);
          chk(g_data == mem_word(pa_of(va)), "R2 R7 R11 hit data", g_data,
              mem_word(pa_of(va)));
          chk(g_lat == 1, "R2 hit latency", 32'(g_lat), 32'd1);
          chk(mem_cnt == mc0, "R2 no memory traffic on hit", 32'(mem_cnt), 32'(mc0));
        end
        2'd1: begin
          chk(g_tmiss && !g_hit && !g_multi, "R3 miss flags",
              {29'd0, g_tmiss, g_hit, g_multi}, 32'd4);
          chk(g_lat == 1, "R3 miss latency", 32'(g_lat), 32'd1);
          chk(mem_cnt == mc0, "R3 no memory request", 32'(mem_cnt), 32'(mc0));
          chk(g_attr == 5'd0, "R10 attr zero on miss", 32'(g_attr), 32'd0);
        end
        default: begin
          chk(g_cmiss && !g_hit && !g_tmiss, "R5 fill flags",
              {29'd0, g_cmiss, g_hit, g_tmiss}, 32'd4);
          chk(g_data == mem_word(pa_of(va)), "R5 fill data", g_data,
              mem_word(pa_of(va)));
          chk(mem_cnt == mc0 + 1, "R4 one memory request", 32'(mem_cnt), 32'(mc0 + 1));
          chk(mem_last == pa_of(va), "R4 memory address", mem_last, pa_of(va));
        end
      endcase
    end

    // R10: referenced bit reported before and after first use
    refill(20'h00200, 1'b0, 3'b010);
    do_req(32'h0020_0200);
    chk(g_cmiss && g_attr == 5'b00010, "R10 attr on first use", 32'(g_attr), 32'h02);
    do_req(32'h0020_0200);
    chk(g_hit && g_attr == 5'b01010, "R10 attr after use", 32'(g_attr), 32'h0A);

    // R8: eight more refills wrap the pointer over all older entries
    for (int k = 0; k < 8; k++) refill(20'h00300 + 20'(k), 1'b0, 3'b100);
    do_req(32'h0020_0200);
    chk(g_tmiss && !g_multi, "R8 oldest entry replaced",
        {30'd0, g_tmiss, g_multi}, 32'd2);
    do_req(32'h0001_0040);
    chk(g_tmiss, "R8 first table entry replaced", 32'(g_tmiss), 32'd1);
    do_req(32'h0030_7040);
    chk(!g_tmiss && g_attr == 5'b00100, "R8 newest entry present, referenced clear",
        32'(g_attr), 32'h04);

    // R6: request side stays closed while the fill is held off
    begin
      int mc0;
      bit closed;
      mc0 = mem_cnt;
      closed = 1'b1;
      mem_hold = 1'b1;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 32'h0030_0100;
      @(posedge clk);
      @(negedge clk);
      req_vaddr = 32'h0030_1104;
      for (int c = 0; c < 12; c++) begin
        if (req_ready || rsp_valid) closed = 1'b0;
        @(negedge clk);
      end
      chk(closed, "R6 closed during pending fill", 32'(closed), 32'd1);
      chk(mem_cnt == mc0 + 1, "R6 single memory request", 32'(mem_cnt), 32'(mc0 + 1));
      req_valid = 1'b0;
      mem_hold = 1'b0;
      g_lat = 0;
      while (!rsp_valid && g_lat < 50) begin
        @(negedge clk);
        g_lat++;
      end
      chk(rsp_valid && rsp_cache_miss && rsp_data == mem_word(pa_of(32'h0030_0100)),
          "R6 held request completes", rsp_data, mem_word(pa_of(32'h0030_0100)));
      @(negedge clk);
      chk(req_ready == 1'b1, "R6 open again after response", 32'(req_ready), 32'd1);
    end

    // R9: duplicate translation entries
    refill(20'h00400, 1'b0, 3'b001);
    refill(20'h00400, 1'b0, 3'b001);
    do_req(32'h0040_0010);
    chk(g_tmiss && g_multi && !g_hit, "R9 multi-match flags",
        {29'd0, g_tmiss, g_multi, g_hit}, 32'd6);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule